// File: doc/BRIEF.md
# Cell Transmit Port with Address Polling

This block is the transmit-side cell port of a physical-layer device, facing an ATM layer controller. The controller writes cells one byte at a time over an 8-bit bus, with a start-of-cell strobe on byte 0. The bytes go into an internal transmit FIFO. A cell becomes visible to the line-side reader only after all 53 bytes have arrived. A cell-available output tells the controller whether there is room for more data.

There are two bus modes. The block leaves reset in shared-bus (multi-PHY) mode. In this mode several devices sit on one bus and each has a programmable 5-bit address. The controller polls an address and, one clock later, the matching device drives cell-available with its output enable high. The controller selects a device by presenting its address on the cycle before the write enable rises. A configuration write can switch the block to point-to-point (single-PHY) mode. In that mode cell-available is always driven and acts as a plain request-to-send flow control line. In either mode, availability follows one of two handshake rules. Cell-level means room for a whole cell. Octet-level means at least four free byte slots.

The block has three state machines:

- **Selection machine** with states `SEL_OFF` and `SEL_ON`:
  - Go-select: `SEL_OFF` moves to `SEL_ON` on a cycle where the write enable is low and the bus address matches.
  - Deselect: `SEL_ON` moves to `SEL_OFF` on a cycle where the write enable is low and the bus address does not match.
  - Hold: the state is kept while the write enable is high.
- **Cell assembly machine** with states `CELL_IDLE`, `CELL_BODY` and `CELL_DISCARD`:
  - Start: an accepted byte that carries the start strobe, with sealed space free, leads to `CELL_BODY` from any state. This restarts a cell.
  - Collect: an accepted byte without the strobe stays in `CELL_BODY`.
  - Finish: accepting the 53rd byte moves to `CELL_IDLE` and seals the cell.
  - Overflow: a byte accepted while the FIFO is full moves to `CELL_DISCARD` and drops the partial cell.
  - Stray: a byte without the strobe in `CELL_IDLE` or `CELL_DISCARD` is ignored and the state is kept.

Top module: `txc_port`

## Requirements
- R1: After reset the block is in multi-PHY mode. Both configuration registers read 0, and `cav_oe` is 0 during reset. After reset, `cav_oe` follows the poll address: it is 1 when polling address 0 and 0 when polling address 1.
- R2: The address register at offset 0x70 holds the address in bits 4:0. Its bits 7:5 read 0 and ignore writes. The mode register at offset 0x71 has bit 0 = single-PHY and bit 1 = cell-level handshake. Its other bits read 0. Any other offset reads 0.
- R3: In multi-PHY mode, `cav_oe` is 1 on the clock after `bus_addr` equals the programmed address, and 0 otherwise. While `cav_oe` is 1, `cav` gives the availability. When `cav_oe` is 0, `cav` is 0.
- R4: Address 31 never matches, even when it is programmed. It never enables `cav_oe` and never selects the device.
- R5: In multi-PHY mode, a byte is accepted only while `tx_wen` is 1 and the address sampled on the last cycle with `tx_wen` low matched. The device stays selected for the whole cell even if `bus_addr` changes while `tx_wen` stays high.
- R6: In single-PHY mode, `cav_oe` is 1 on every clock whatever the bus address, and bytes are accepted whenever `tx_wen` is 1.
- R7: With cell-level handshaking, `cav` is 1 one clock later only if the free FIFO space, counting the bytes of a partial cell, is at least 53.
- R8: With octet-level handshaking, `cav` is 1 one clock later only if at least 4 byte slots are free.
- R9: A cell is 53 bytes with `tx_soc` high on byte 0. Complete cells reach the line side byte for byte, in the order they were written. Bytes without `tx_soc` that arrive outside a cell are ignored.
- R10: A `tx_soc` in the middle of a cell drops the partial cell, and the strobed byte starts a new cell.
- R11: A byte accepted while the FIFO is full discards the whole cell in progress. The cells sealed before it are unaffected.
- R12: `line_avail` is 1 only while at least one complete cell byte is unread. Bytes of a partial cell are never offered to the line side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` (combinational) |
| bus_addr | input | 5 | Poll/select address driven by the controller |
| tx_wen | input | 1 | Write enable, active high |
| tx_soc | input | 1 | Start-of-cell strobe for byte 0 |
| tx_data | input | 8 | Cell byte |
| cav | output | 1 | Cell-available / flow control |
| cav_oe | output | 1 | Output enable of `cav`; 0 models a released line |
| line_rd | input | 1 | Line-side pop of one byte |
| line_data | output | 8 | Oldest unread sealed byte |
| line_avail | output | 1 | A sealed byte is available |

## Verification
A wrong selection state shows up as a whole cell that is either missing or present on the line side. This is visible on `line_avail` one clock after the 53rd byte. A wrong poll register shows up at `cav_oe` on the very next clock after the address changes, and the sweeps cover every address against several programmed values. Pointer or commit errors show up as wrong byte values or early `line_avail` when the FIFO is drained. A wrong free-space count flips `cav` one clock after the byte at a threshold, and byte-by-byte stepping across the 53, 4 and full boundaries catches this.

// File: rtl/txc_pkg.sv
package txc_pkg;

    typedef enum logic {
        SEL_OFF,
        SEL_ON
    } sel_state_t;

    typedef enum logic [1:0] {
        CELL_IDLE,
        CELL_BODY,
        CELL_DISCARD
    } cell_state_t;

endpackage

// File: rtl/txc_regs.sv
module txc_regs #(
    parameter int         ADDR_W   = 5,
    parameter logic [7:0] ADDR_OFS = 8'h70,
    parameter logic [7:0] MODE_OFS = 8'h71
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic [ADDR_W-1:0] my_addr,
    output logic              mode_single,
    output logic              mode_cell
);

    localparam int PAD_W = 8 - ADDR_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            my_addr     <= '0;
            mode_single <= 1'b0;
            mode_cell   <= 1'b0;
        end else if (cfg_wr) begin
            if (cfg_addr == ADDR_OFS) begin
                my_addr <= cfg_wdata[ADDR_W-1:0];
            end
            if (cfg_addr == MODE_OFS) begin
                mode_single <= cfg_wdata[0];
                mode_cell   <= cfg_wdata[1];
            end
        end
    end

    always_comb begin
        if (cfg_addr == ADDR_OFS) begin
            cfg_rdata = {{PAD_W{1'b0}}, my_addr};
        end else if (cfg_addr == MODE_OFS) begin
            cfg_rdata = {6'b0, mode_cell, mode_single};
        end else begin
            cfg_rdata = 8'h00;
        end
    end

endmodule

// File: rtl/txc_select.sv
module txc_select
    import txc_pkg::*;
#(
    parameter int ADDR_W       = 5,
    parameter int FIFO_AW      = 7,
    parameter int CELL_BYTES   = 53,
    parameter int OCTET_MARGIN = 4,
    parameter int NULL_ADDR    = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_single,
    input  logic               mode_cell,
    input  logic [ADDR_W-1:0]  my_addr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               tx_wen,
    input  logic [FIFO_AW:0]   free,
    output logic               write_ok,
    output logic               cav,
    output logic               cav_oe
);

    localparam int PW = FIFO_AW + 1;

    sel_state_t sel_state, sel_next;
    logic       match;
    logic       room_ok;
    logic       oe_q;
    logic       cav_q;

    assign match = (bus_addr == my_addr) && (bus_addr != ADDR_W'(NULL_ADDR));

    always_comb begin
        if (mode_cell) begin
            room_ok = free >= PW'(CELL_BYTES);
        end else begin
            room_ok = free >= PW'(OCTET_MARGIN);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_state <= SEL_OFF;
        end else begin
            sel_state <= sel_next;
        end
    end

    // transitions: address is sampled only while the write enable is low
    always_comb begin
        sel_next = sel_state;
        unique case (sel_state)
            SEL_OFF: if (!tx_wen && match)  sel_next = SEL_ON;
            SEL_ON:  if (!tx_wen && !match) sel_next = SEL_OFF;
        endcase
    end

    // poll response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            cav_q <= 1'b0;
        end else begin
            oe_q  <= mode_single || match;
            cav_q <= (mode_single || match) && room_ok;
        end
    end

    // outputs
    always_comb begin
        write_ok = mode_single || (sel_state == SEL_ON);
        cav_oe   = oe_q;
        cav      = cav_q;
    end

endmodule

// File: rtl/txc_cellfsm.sv
module txc_cellfsm
    import txc_pkg::*;
#(
    parameter int CELL_BYTES = 53
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic soc,
    input  logic full_now,
    input  logic full_sealed,
    output logic push,
    output logic rewind,
    output logic drop,
    output logic seal
);

    localparam int CW = $clog2(CELL_BYTES);
    localparam logic [CW-1:0] LAST = CW'(CELL_BYTES - 1);

    cell_state_t state, state_next;
    logic [CW-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CELL_IDLE;
        end else begin
            state <= state_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push) begin
            cnt <= rewind ? CW'(1) : cnt + CW'(1);
        end
    end

    // transitions
    always_comb begin
        state_next = state;
        unique case (state)
            CELL_IDLE, CELL_DISCARD: begin
                if (accept && soc) begin
                    state_next = full_sealed ? CELL_DISCARD : CELL_BODY;
                end
            end
            CELL_BODY: begin
                if (accept && soc) begin
                    state_next = full_sealed ? CELL_DISCARD : CELL_BODY;
                end else if (accept) begin
                    if (full_now) begin
                        state_next = CELL_DISCARD;
                    end else if (cnt == LAST) begin
                        state_next = CELL_IDLE;
                    end
                end
            end
            default: state_next = CELL_IDLE;
        endcase
    end

    // outputs to the FIFO
    always_comb begin
        push   = 1'b0;
        rewind = 1'b0;
        drop   = 1'b0;
        seal   = 1'b0;
        if (accept) begin
            if (soc) begin
                if (full_sealed) begin
                    drop = 1'b1;
                end else begin
                    push   = 1'b1;
                    rewind = 1'b1;
                end
            end else if (state == CELL_BODY) begin
                if (full_now) begin
                    drop = 1'b1;
                end else begin
                    push = 1'b1;
                    seal = (cnt == LAST);
                end
            end
        end
    end

endmodule

// File: rtl/txc_fifo.sv
module txc_fifo #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          rewind,
    input  logic          drop,
    input  logic          seal,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          avail,
    output logic [AW:0]   free,
    output logic [AW:0]   used,
    output logic          full_now,
    output logic          full_sealed
);

    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] seal_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wbase;
    logic [PW-1:0] sealed_used;

    assign wbase = rewind ? seal_ptr : wr_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wbase[AW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            seal_ptr <= '0;
            rd_ptr   <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wbase + PW'(1);
                if (seal) begin
                    seal_ptr <= wbase + PW'(1);
                end
            end else if (drop) begin
                wr_ptr <= seal_ptr;
            end
            if (pop && avail) begin
                rd_ptr <= rd_ptr + PW'(1);
            end
        end
    end

    always_comb begin
        used        = wr_ptr - rd_ptr;
        sealed_used = seal_ptr - rd_ptr;
        free        = DEPTH_P - used;
        full_now    = (used == DEPTH_P);
        full_sealed = (sealed_used == DEPTH_P);
        avail       = (rd_ptr != seal_ptr);
        rdata       = mem[rd_ptr[AW-1:0]];
    end

endmodule

// File: rtl/txc_port.sv
module txc_port #(
    parameter int ADDR_W       = 5,
    parameter int FIFO_AW      = 7,
    parameter int CELL_BYTES   = 53,
    parameter int OCTET_MARGIN = 4,
    parameter int NULL_ADDR    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              tx_wen,
    input  logic              tx_soc,
    input  logic [7:0]        tx_data,
    output logic              cav,
    output logic              cav_oe,
    input  logic              line_rd,
    output logic [7:0]        line_data,
    output logic              line_avail
);

    logic [ADDR_W-1:0] my_addr;
    logic              mode_single;
    logic              mode_cell;
    logic              write_ok;
    logic              accept;
    logic              fifo_push;
    logic              fifo_rewind;
    logic              fifo_drop;
    logic              fifo_seal;
    logic              full_now;
    logic              full_sealed;
    logic [FIFO_AW:0]  fifo_free;
    logic [FIFO_AW:0]  fifo_used;

    assign accept = tx_wen && write_ok;

    txc_regs #(
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .my_addr     (my_addr),
        .mode_single (mode_single),
        .mode_cell   (mode_cell)
    );

    txc_select #(
        .ADDR_W       (ADDR_W),
        .FIFO_AW      (FIFO_AW),
        .CELL_BYTES   (CELL_BYTES),
        .OCTET_MARGIN (OCTET_MARGIN),
        .NULL_ADDR    (NULL_ADDR)
    ) i_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_single (mode_single),
        .mode_cell   (mode_cell),
        .my_addr     (my_addr),
        .bus_addr    (bus_addr),
        .tx_wen      (tx_wen),
        .free        (fifo_free),
        .write_ok    (write_ok),
        .cav         (cav),
        .cav_oe      (cav_oe)
    );

    txc_cellfsm #(
        .CELL_BYTES (CELL_BYTES)
    ) i_cellfsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .soc         (tx_soc),
        .full_now    (full_now),
        .full_sealed (full_sealed),
        .push        (fifo_push),
        .rewind      (fifo_rewind),
        .drop        (fifo_drop),
        .seal        (fifo_seal)
    );

    txc_fifo #(
        .AW (FIFO_AW),
        .DW (8)
    ) i_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (fifo_push),
        .rewind      (fifo_rewind),
        .drop        (fifo_drop),
        .seal        (fifo_seal),
        .wdata       (tx_data),
        .pop         (line_rd),
        .rdata       (line_data),
        .avail       (line_avail),
        .free        (fifo_free),
        .used        (fifo_used),
        .full_now    (full_now),
        .full_sealed (full_sealed)
    );

endmodule

// File: rtl/txc_port_chk.sv
module txc_port_chk #(
    parameter int ADDR_W       = 5,
    parameter int FIFO_AW      = 7,
    parameter int CELL_BYTES   = 53,
    parameter int OCTET_MARGIN = 4,
    parameter int NULL_ADDR    = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_single,
    input logic              mode_cell,
    input logic [ADDR_W-1:0] my_addr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tx_wen,
    input logic              fifo_push,
    input logic [FIFO_AW:0]  fifo_free,
    input logic [FIFO_AW:0]  fifo_used,
    input logic              cav,
    input logic              cav_oe
);

    localparam int PW = FIFO_AW + 1;

    AST_CAV_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        cav |-> cav_oe); // R3
    AST_POLL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_single && bus_addr == my_addr && bus_addr != ADDR_W'(NULL_ADDR)) |=> cav_oe); // R3
    AST_POLL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_single && bus_addr != my_addr) |=> !cav_oe); // R3
    AST_NULL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_single && bus_addr == ADDR_W'(NULL_ADDR)) |=> !cav_oe); // R4
    AST_WRITE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> tx_wen); // R5
    AST_SINGLE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_single |=> cav_oe); // R6
    AST_CELL_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cell && fifo_free < PW'(CELL_BYTES)) |=> !cav); // R7
    AST_OCTET_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_cell && fifo_free < PW'(OCTET_MARGIN)) |=> !cav); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_used <= PW'(1 << FIFO_AW)); // R11

endmodule

bind txc_port txc_port_chk #(
    .ADDR_W       (ADDR_W),
    .FIFO_AW      (FIFO_AW),
    .CELL_BYTES   (CELL_BYTES),
    .OCTET_MARGIN (OCTET_MARGIN),
    .NULL_ADDR    (NULL_ADDR)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_single (mode_single),
    .mode_cell   (mode_cell),
    .my_addr     (my_addr),
    .bus_addr    (bus_addr),
    .tx_wen      (tx_wen),
    .fifo_push   (fifo_push),
    .fifo_free   (fifo_free),
    .fifo_used   (fifo_used),
    .cav         (cav),
    .cav_oe      (cav_oe)
);

// File: tb/test_txc_port.sv
module test_txc_port;

    localparam int CLK_PERIOD = 10;
    localparam int CELL       = 53;
    localparam int DEPTH      = 128;
    localparam logic [4:0] MY = 5'd9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [4:0] bus_addr = 5'd1;
    logic       tx_wen = 1'b0;
    logic       tx_soc = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       cav;
    logic       cav_oe;
    logic       line_rd = 1'b0;
    logic [7:0] line_data;
    logic       line_avail;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txc_port i_txc_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .bus_addr   (bus_addr),
        .tx_wen     (tx_wen),
        .tx_soc     (tx_soc),
        .tx_data    (tx_data),
        .cav        (cav),
        .cav_oe     (cav_oe),
        .line_rd    (line_rd),
        .line_data  (line_data),
        .line_avail (line_avail)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_check(input string req, input logic [7:0] a, input int exp);
        cfg_addr = a;
        #1;
        chk(req, int'(cfg_rdata), exp);
    endtask

    // present an address with the write enable low for one clock
    task automatic poll(input logic [4:0] a);
        tx_wen = 1'b0; tx_soc = 1'b0; bus_addr = a;
        tick();
    endtask

    task automatic send_bytes(input logic [7:0] seed, input int n, input bit soc_first);
        for (int i = 0; i < n; i++) begin
            tx_wen = 1'b1;
            tx_soc = soc_first && (i == 0);
            tx_data = seed + 8'(i);
            bus_addr = 5'(i);
            tick();
        end
        tx_wen = 1'b0; tx_soc = 1'b0;
    endtask

    // one byte, then an idle cycle on our own address so cav reflects it
    task automatic wbyte(input logic [7:0] d, input bit soc);
        tx_wen = 1'b1; tx_soc = soc; tx_data = d;
        tick();
        tx_wen = 1'b0; tx_soc = 1'b0; bus_addr = MY;
        tick();
    endtask

    task automatic drain(input string req, input logic [7:0] seed, input int n);
        for (int i = 0; i < n; i++) begin
            chk(req, int'(line_avail), 1);
            chk(req, int'(line_data), int'(seed + 8'(i)));
            line_rd = 1'b1;
            tick();
            line_rd = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int progs[5] = '{0, 5, 17, 30, 31};
        repeat (3) tick();
        // R1: reset state
        chk("R1 oe in reset", int'(cav_oe), 0);
        chk("R1 cav in reset", int'(cav), 0);
        chk("R1 line in reset", int'(line_avail), 0);
        cfg_check("R1 addr reg", 8'h70, 0);
        cfg_check("R1 mode reg", 8'h71, 0);
        rst_n = 1'b1;
        poll(5'd1);
        chk("R1 multi miss", int'(cav_oe), 0);
        poll(5'd0);
        chk("R1 multi hit", int'(cav_oe), 1);

        // R2: register fields
        cfg_write(8'h70, 8'hFF);
        cfg_check("R2 addr mask", 8'h70, 8'h1F);
        cfg_write(8'h70, 8'hE5);
        cfg_check("R2 addr write", 8'h70, 8'h05);
        cfg_write(8'h71, 8'hFE);
        cfg_check("R2 mode mask", 8'h71, 8'h02);
        cfg_write(8'h71, 8'h00);
        cfg_check("R2 mode clear", 8'h71, 8'h00);
        cfg_check("R2 other offset", 8'h6C, 0);

        // R3 / R4: poll sweep over every address for several programmed values
        foreach (progs[p]) begin
            cfg_write(8'h70, 8'(progs[p]));
            for (int a = 0; a < 32; a++) begin
                int exp_oe;
                poll(5'(a));
                exp_oe = (a == progs[p] && progs[p] != 31) ? 1 : 0;
                chk(progs[p] == 31 ? "R4 null poll oe" : "R3 poll oe", int'(cav_oe), exp_oe);
                chk("R3 poll cav", int'(cav), exp_oe);
            end
        end

        // R4: null address cannot be selected
        poll(5'd31);
        send_bytes(8'h01, CELL, 1'b1);
        tick();
        chk("R4 null select", int'(line_avail), 0);

        // R5: selection
        cfg_write(8'h70, {3'b0, MY});
        poll(5'd3);
        send_bytes(8'h20, CELL, 1'b1);
        tick();
        chk("R5 unselected ignored", int'(line_avail), 0);
        poll(MY);
        chk("R5 space untouched", int'(cav), 1);
        send_bytes(8'h30, CELL, 1'b1);
        chk("R5 selected accepted", int'(line_avail), 1);
        drain("R9 cell data", 8'h30, CELL);
        chk("R12 drained", int'(line_avail), 0);

        // R10 / R12: mid-cell start strobe
        poll(MY);
        send_bytes(8'h40, 20, 1'b1);
        chk("R12 partial hidden", int'(line_avail), 0);
        poll(MY);
        send_bytes(8'h60, CELL, 1'b1);
        drain("R10 restarted cell", 8'h60, CELL);
        chk("R10 partial dropped", int'(line_avail), 0);

        // R9: stray bytes outside a cell ignored
        poll(MY);
        send_bytes(8'h70, 5, 1'b0);
        chk("R9 stray ignored", int'(line_avail), 0);
        poll(MY);
        send_bytes(8'h80, CELL, 1'b1);
        drain("R9 after stray", 8'h80, CELL);
        chk("R9 only one cell", int'(line_avail), 0);

        // R7: cell-level handshake
        cfg_write(8'h71, 8'h02);
        poll(MY);
        chk("R7 empty", int'(cav), 1);
        send_bytes(8'h10, CELL, 1'b1);
        poll(MY);
        chk("R7 free 75", int'(cav), 1);
        send_bytes(8'h50, CELL, 1'b1);
        poll(MY);
        chk("R7 free 22", int'(cav), 0);
        drain("R9 order first", 8'h10, CELL);
        poll(MY);
        chk("R7 free 75 again", int'(cav), 1);
        send_bytes(8'hA0, 22, 1'b1);
        poll(MY);
        chk("R7 free 53", int'(cav), 1);
        wbyte(8'hA0 + 8'd22, 1'b0);
        chk("R7 free 52", int'(cav), 0);
        send_bytes(8'hA0 + 8'd23, CELL - 23, 1'b0);
        drain("R9 order second", 8'h50, CELL);
        drain("R7 cell after steps", 8'hA0, CELL);
        chk("R12 empty", int'(line_avail), 0);

        // R6 / R8 / R11: single-PHY, octet handshake, overflow
        cfg_write(8'h71, 8'h01);
        cfg_check("R2 single bit", 8'h71, 1);
        poll(5'd31);
        chk("R6 oe any addr", int'(cav_oe), 1);
        chk("R6 cav", int'(cav), 1);
        send_bytes(8'h90, CELL, 1'b1);
        send_bytes(8'hC0, CELL, 1'b1);
        chk("R6 accepted without select", int'(line_avail), 1);
        for (int k = 0; k <= 22; k++) begin
            int freeb;
            int exp_cav;
            wbyte(8'hE0 + 8'(k), k == 0);
            freeb = DEPTH - 2 * CELL - (k + 1);
            exp_cav = (k < 22) ? ((freeb >= 4) ? 1 : 0) : 1;
            chk(k < 22 ? "R8 octet room" : "R11 discard frees", int'(cav), exp_cav);
            chk("R6 oe held", int'(cav_oe), 1);
        end
        drain("R11 sealed kept 1", 8'h90, CELL);
        drain("R11 sealed kept 2", 8'hC0, CELL);
        chk("R11 overflowed cell gone", int'(line_avail), 0);
        send_bytes(8'h11, CELL, 1'b1);
        drain("R11 recovery", 8'h11, CELL);
        chk("R12 final empty", int'(line_avail), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule